// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Port

This block is a general-purpose I/O port of up to 32 lines. Software controls it over a simple 32-bit register bus. Each configuration field is a per-line bit vector. Software never writes such a vector directly. It writes a mask to a "set" address to turn bits on, or to a paired "clear" address to turn bits off. Bits written as zero keep their value, so two agents can change different lines without a read-modify-write race.

Every input line is brought into the clock domain by a two-flop synchroniser. An optional per-line glitch filter can follow it. The line's detector then compares the current filtered sample with the previous one. A line can interrupt on a high or low level, on a rising or falling edge, or on both edges. The both-edges setting overrides the other two settings for that line. Edge events latch a status bit until software acknowledges them. Level events show in status only while the level lasts. The unmasked statuses are ORed together and drive a single interrupt output, which has its own enable.

The bus has no back-pressure. Every write takes effect on the clock edge that samples it. A read returns its data on the clock edge that samples the read strobe, and the data holds until the next read. The port pins are plain signals.

Top module: `gpio_irq_port`

## Requirements
- R1: A write to a set address ORs the written bits into the addressed vector. A write to its clear address (set address + 4) removes the written bits. Other bits are unchanged. The set addresses are: output data 0x00, direction 0x10, interrupt enable 0x20, interrupt mask 0x30, edge-type 0x40, polarity 0x50, glitch filter 0x60, both-edges 0xB0. The direction vector reads back at 0x18.
- R2: `pin_oe` equals the direction vector. `pin_out` carries the output-data bit only on lines whose direction bit is 1, and is 0 on every other line.
- R3: A read of 0x80 returns the synchronised input levels. A change on `pin_in` is not visible on the first clock edge after it, and is visible within four clock edges.
- R4: With edge-type 0 and both-edges 0, a line is in level mode. Polarity 1 asserts the line's status while the input is high. Polarity 0 asserts it while the input is low.
- R5: With edge-type 1 and both-edges 0, polarity 1 latches status on a rising input edge and polarity 0 latches it on a falling edge. The opposite edge has no effect.
- R6: With both-edges 1, a line latches status on either input edge, whatever its edge-type and polarity bits hold.
- R7: Writing 1 to a bit of 0x78 clears that line's latched edge status. The same write leaves a level-mode line's status unchanged. The status vector reads at 0x70.
- R8: When an acknowledge write to 0x78 falls on the same clock edge at which a new edge is recognised on that line, the status stays set.
- R9: A line whose enable bit is 0 shows status 0. Clearing the enable bit discards a latched edge, which does not come back when the line is enabled again.
- R10: `irq_out` is 1 exactly when bit 0 of the register at 0xA0 (written directly, not through a set/clear pair) is 1 and some line has status 1 with its mask bit 0. The mask does not hide the status read at 0x70.
- R11: On a line whose glitch-filter bit is 1, an input pulse one clock long produces no event. A level held for several clocks passes.
- R12: After reset, every vector is 0. So all lines are inputs, `pin_out` is 0, status is 0 and `irq_out` is 0.
- R13: Bits at or above `NUM_LINES` in written data have no effect, and they read as 0. The both-edges vector reads at 0xB8, and unlisted addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one transfer per asserted cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, updated on the edge that samples `bus_rd` |
| pin_in | input | NUM_LINES | Asynchronous input levels of the lines |
| pin_out | output | NUM_LINES | Output value for each line |
| pin_oe | output | NUM_LINES | Output enable for each line |
| irq_out | output | 1 | Combined interrupt |

## Verification
The edge detector and the acknowledge decoder can both act on the same line in the same cycle: a new edge arrives while software is acknowledging the previous one. The bench changes the input, counts clock edges through the synchroniser and the filter stage, and places the acknowledge write on the exact edge at which the detector sees the transition. It then expects the status bit still to be set. A second acknowledge one cycle later must clear the bit, which shows that the first acknowledge did not land after the edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int BUS_W     = 32;
  localparam int ADDR_W    = 8;
  localparam int MAX_LINES = 32;

  // set addresses of the set/clear vector pairs; clear address is +4
  localparam int NUM_PAIRS = 8;
  localparam int P_OUT  = 0;
  localparam int P_DIR  = 1;
  localparam int P_IEN  = 2;
  localparam int P_MSK  = 3;
  localparam int P_TRIG = 4;
  localparam int P_POL  = 5;
  localparam int P_FLT  = 6;
  localparam int P_BOTH = 7;
  localparam logic [ADDR_W-1:0] PAIR_SET_ADDR [NUM_PAIRS] =
    '{8'h00, 8'h10, 8'h20, 8'h30, 8'h40, 8'h50, 8'h60, 8'hB0};

  // plain addresses
  localparam logic [ADDR_W-1:0] A_DIR_RD  = 8'h18;
  localparam logic [ADDR_W-1:0] A_STAT_RD = 8'h70;
  localparam logic [ADDR_W-1:0] A_ACK     = 8'h78;
  localparam logic [ADDR_W-1:0] A_PIN_RD  = 8'h80;
  localparam logic [ADDR_W-1:0] A_TOP_EN  = 8'hA0;
  localparam logic [ADDR_W-1:0] A_BOTH_RD = 8'hB8;

  typedef struct packed {
    logic ien;
    logic trig;
    logic pol;
    logic both;
  } line_cfg_t;
endpackage

// File: rtl/gpio_irq_setclr.sv
module gpio_irq_setclr
  import gpio_irq_pkg::*;
#(
  parameter int                NUM_LINES = 32,
  parameter logic [ADDR_W-1:0] SET_A     = 8'h00
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BUS_W-1:0]     bus_wdata,
  output logic [NUM_LINES-1:0] q
);
  localparam logic [ADDR_W-1:0] CLR_A = SET_A + 8'd4;

  logic [NUM_LINES-1:0] bits;
  logic                 hit_set, hit_clr;

  assign bits    = bus_wdata[NUM_LINES-1:0];
  assign hit_set = bus_wr && (bus_addr == SET_A);
  assign hit_clr = bus_wr && (bus_addr == CLR_A);

  always_ff @(posedge clk) begin
    if (!rst_n)       q <= '0;
    else if (hit_set) q <= q | bits;
    else if (hit_clr) q <= q & ~bits;
  end

  // R1: written ones are present after a set write
  assert_set_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == SET_A) |=>
      ((q & $past(bus_wdata[NUM_LINES-1:0])) == $past(bus_wdata[NUM_LINES-1:0])));

  // R1: written ones are gone after a clear write
  assert_clr_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == CLR_A) |=>
      ((q & $past(bus_wdata[NUM_LINES-1:0])) == '0));
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BUS_W-1:0]     bus_wdata,
  output logic [NUM_LINES-1:0] vec_q [NUM_PAIRS],
  output logic                 top_en_q,
  output logic [NUM_LINES-1:0] ack_bits
);
  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    gpio_irq_setclr #(
      .NUM_LINES(NUM_LINES),
      .SET_A    (PAIR_SET_ADDR[k])
    ) i_pair (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .q        (vec_q[k])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                top_en_q <= 1'b0;
    else if (bus_wr && bus_addr == A_TOP_EN)   top_en_q <= bus_wdata[0];
  end

  assign ack_bits = (bus_wr && bus_addr == A_ACK) ? bus_wdata[NUM_LINES-1:0] : '0;
endmodule

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] pin_in,
  input  logic [NUM_LINES-1:0] flt_en,
  output logic [NUM_LINES-1:0] lvl_q,
  output logic [NUM_LINES-1:0] prv_q
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic s1, s2, s3;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1       <= 1'b0;
        s2       <= 1'b0;
        s3       <= 1'b0;
        lvl_q[i] <= 1'b0;
        prv_q[i] <= 1'b0;
      end else begin
        s1       <= pin_in[i];
        s2       <= s1;
        s3       <= s2;
        prv_q[i] <= lvl_q[i];
        if (!flt_en[i] || (s2 == s3)) lvl_q[i] <= s2;
      end
    end

    // R11: with the filter on, the level only moves to a value seen on two samples
    assert_filter_agree_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_en[i] && $past(flt_en[i]) && !$stable(lvl_q[i])) |-> (lvl_q[i] == $past(s3)));
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lvl,
  input  logic [NUM_LINES-1:0] prv,
  input  logic [NUM_LINES-1:0] ien,
  input  logic [NUM_LINES-1:0] trig,
  input  logic [NUM_LINES-1:0] pol,
  input  logic [NUM_LINES-1:0] both,
  input  logic [NUM_LINES-1:0] ack,
  output logic [NUM_LINES-1:0] status
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    line_cfg_t cfg;
    logic rise, fall, edge_mode, hit, level_on, latch;

    assign cfg       = '{ien: ien[i], trig: trig[i], pol: pol[i], both: both[i]};
    assign rise      = lvl[i] & ~prv[i];
    assign fall      = ~lvl[i] & prv[i];
    assign edge_mode = cfg.both | cfg.trig;
    assign hit       = cfg.both ? (rise | fall) : (cfg.trig & (cfg.pol ? rise : fall));
    assign level_on  = ~edge_mode & (cfg.pol ? lvl[i] : ~lvl[i]);

    always_ff @(posedge clk) begin
      if (!rst_n)                      latch <= 1'b0;
      else if (!cfg.ien || !edge_mode) latch <= 1'b0;
      else if (hit)                    latch <= 1'b1;
      else if (ack[i])                 latch <= 1'b0;
    end

    assign status[i] = cfg.ien & (latch | level_on);

    // R7: an acknowledge with no new edge empties an edge-mode line
    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[i] && !hit && edge_mode) |=> !status[i]);

    // R8: a recognised edge wins over a coinciding acknowledge
    assert_edge_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && cfg.ien) |=> (status[i] || !cfg.ien));

    // R9: a disabled line never reports
    assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.ien |-> !status[i]);
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BUS_W-1:0]     bus_wdata,
  output logic [BUS_W-1:0]     bus_rdata,
  input  logic [NUM_LINES-1:0] pin_in,
  output logic [NUM_LINES-1:0] pin_out,
  output logic [NUM_LINES-1:0] pin_oe,
  output logic                 irq_out
);
  logic [NUM_LINES-1:0] vec_q [NUM_PAIRS];
  logic                 top_en_q;
  logic [NUM_LINES-1:0] ack_bits, lvl_q, prv_q, status;
  logic [BUS_W-1:0]     rd_next;

  gpio_irq_regs #(.NUM_LINES(NUM_LINES)) i_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .vec_q    (vec_q),
    .top_en_q (top_en_q),
    .ack_bits (ack_bits)
  );

  gpio_irq_sync #(.NUM_LINES(NUM_LINES)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_in(pin_in),
    .flt_en(vec_q[P_FLT]),
    .lvl_q (lvl_q),
    .prv_q (prv_q)
  );

  gpio_irq_detect #(.NUM_LINES(NUM_LINES)) i_detect (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (lvl_q),
    .prv   (prv_q),
    .ien   (vec_q[P_IEN]),
    .trig  (vec_q[P_TRIG]),
    .pol   (vec_q[P_POL]),
    .both  (vec_q[P_BOTH]),
    .ack   (ack_bits),
    .status(status)
  );

  always_comb begin
    rd_next = '0;
    case (bus_addr)
      A_DIR_RD:  rd_next[NUM_LINES-1:0] = vec_q[P_DIR];
      A_STAT_RD: rd_next[NUM_LINES-1:0] = status;
      A_PIN_RD:  rd_next[NUM_LINES-1:0] = lvl_q;
      A_BOTH_RD: rd_next[NUM_LINES-1:0] = vec_q[P_BOTH];
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  assign pin_oe  = vec_q[P_DIR];
  assign pin_out = vec_q[P_OUT] & vec_q[P_DIR];
  assign irq_out = top_en_q & (|(status & ~vec_q[P_MSK]));

  // R2: a line set as input never drives a one
  assert_input_not_driven_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out & ~pin_oe) == '0));

  // R10: the combined output is silent while its enable is off
  assert_top_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_TOP_EN && !bus_wdata[0]) |=> !irq_out);
endmodule

// File: tb/test_gpio_irq_port.sv
module test_gpio_irq_port;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  localparam logic [7:0] OUT_S = 8'h00, DIR_S = 8'h10, DIR_C = 8'h14, DIR_R = 8'h18;
  localparam logic [7:0] IEN_S = 8'h20, IEN_C = 8'h24, MSK_S = 8'h30, MSK_C = 8'h34;
  localparam logic [7:0] TRG_S = 8'h40, TRG_C = 8'h44, POL_S = 8'h50, POL_C = 8'h54;
  localparam logic [7:0] FLT_S = 8'h60, FLT_C = 8'h64, STAT = 8'h70, ACK = 8'h78;
  localparam logic [7:0] PIN_R = 8'h80, TOP = 8'hA0, BTH_S = 8'hB0, BTH_C = 8'hB4;

  typedef struct packed {
    logic trig; logic pol; logic both; logic from_lvl; logic to_lvl; logic exp_st;
  } vec_t;
  // R4 level, R5 edge, R6 both-edges override
  localparam vec_t VECS [10] = '{
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n, bus_wr, bus_rd, irq_out;
  logic [7:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [N-1:0] pin_in, pin_out, pin_oe;
  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_port #(.NUM_LINES(N)) i_gpio_irq_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
    waitc(3);
    rst_n = 1'b1;
    waitc(1);

    // R12 reset state
    check("R12 pin_oe", 32'(pin_oe), 0);
    check("R12 pin_out", 32'(pin_out), 0);
    check("R12 irq_out", 32'(irq_out), 0);
    rd(DIR_R, r); check("R12 dir", r, 0);
    rd(STAT, r);  check("R12 status", r, 0);

    // R1 / R13 set-clear semantics
    wr(DIR_S, 32'h05);
    wr(DIR_S, 32'hFFFF_FF02);
    rd(DIR_R, r); check("R1 R13 dir set", r, 32'h07);
    wr(DIR_S, 32'hF0);
    wr(DIR_C, 32'h84);
    rd(DIR_R, r); check("R1 dir clear", r, 32'h73);
    rd(8'h44, r); check("R13 unlisted read", r, 0);
    wr(BTH_S, 32'h3C); wr(BTH_C, 32'h0C);
    rd(8'hB8, r); check("R13 both readback", r, 32'h30);
    wr(BTH_C, 32'hFF);

    // R2 output drive
    check("R2 pin_oe", 32'(pin_oe), 32'h73);
    wr(OUT_S, 32'h0F);
    check("R2 pin_out gated", 32'(pin_out), 32'h03);
    wr(DIR_C, 32'hFF);
    check("R2 pin_out inputs", 32'(pin_out), 0);

    // R3 input synchronisation
    pin_in = 8'hA5; waitc(5);
    rd(PIN_R, r); check("R3 pin read", r, 32'hA5);
    pin_in = 8'h5A;
    rd(PIN_R, r); check("R3 not yet visible", r, 32'hA5);
    waitc(3);
    rd(PIN_R, r); check("R3 visible", r, 32'h5A);
    pin_in = '0; waitc(5);

    // vector table: R4 R5 R6 on line 0
    wr(IEN_S, 32'h1); wr(TOP, 32'h1);
    foreach (VECS[v]) begin
      wr(VECS[v].trig ? TRG_S : TRG_C, 32'h1);
      wr(VECS[v].pol  ? POL_S : POL_C, 32'h1);
      wr(VECS[v].both ? BTH_S : BTH_C, 32'h1);
      pin_in[0] = VECS[v].from_lvl; waitc(6);
      wr(ACK, 32'h1);
      pin_in[0] = VECS[v].to_lvl; waitc(6);
      rd(STAT, r);
      check($sformatf("R4 R5 R6 vector %0d", v), 32'(r[0]), 32'(VECS[v].exp_st));
    end
    wr(BTH_C, 32'h1);

    // R7 acknowledge: edge cleared, level kept
    wr(TRG_S, 1); wr(POL_S, 1); pin_in[0] = 1'b0; waitc(6); wr(ACK, 1);
    pin_in[0] = 1'b1; waitc(6);
    rd(STAT, r); check("R7 edge latched", r, 1);
    wr(ACK, 1);
    rd(STAT, r); check("R7 edge cleared", r, 0);
    wr(TRG_C, 1);
    wr(ACK, 1);
    rd(STAT, r); check("R7 level kept", r, 1);

    // R10 masking and combined enable
    check("R10 irq on", 32'(irq_out), 1);
    wr(MSK_S, 1);
    check("R10 masked irq", 32'(irq_out), 0);
    rd(STAT, r); check("R10 status unmasked view", r, 1);
    wr(MSK_C, 1);
    check("R10 unmasked irq", 32'(irq_out), 1);
    wr(TOP, 0);
    check("R10 top off", 32'(irq_out), 0);
    wr(TOP, 1);

    // R9 enable gating
    wr(IEN_C, 1);
    rd(STAT, r); check("R9 disabled level", r, 0);
    check("R9 disabled irq", 32'(irq_out), 0);
    wr(IEN_S, 1); wr(TRG_S, 1); pin_in[0] = 1'b0; waitc(6); wr(ACK, 1);
    pin_in[0] = 1'b1; waitc(6);
    wr(IEN_C, 1); wr(IEN_S, 1);
    rd(STAT, r); check("R9 latch discarded", r, 0);

    // R8 acknowledge on the edge-recognition cycle
    pin_in[0] = 1'b0; waitc(6); wr(ACK, 1);
    pin_in[0] = 1'b1;          // before e1
    waitc(3);                  // after e1, e2, e3: level stage updated
    wr(ACK, 1);                // captured at e4 with the detected edge
    rd(STAT, r); check("R8 edge beats ack", r, 1);
    wr(ACK, 1);
    rd(STAT, r); check("R8 later ack clears", r, 0);

    // R11 glitch filter on line 1, rising edge
    wr(IEN_S, 2); wr(TRG_S, 2); wr(POL_S, 2); wr(FLT_S, 2);
    pin_in[1] = 1'b0; waitc(6); wr(ACK, 2);
    pin_in[1] = 1'b1; waitc(1); pin_in[1] = 1'b0; waitc(6);
    rd(STAT, r); check("R11 pulse filtered", 32'(r[1]), 0);
    wr(FLT_C, 2);
    pin_in[1] = 1'b1; waitc(1); pin_in[1] = 1'b0; waitc(6);
    rd(STAT, r); check("R11 pulse unfiltered", 32'(r[1]), 1);
    wr(FLT_S, 2); wr(ACK, 2);
    pin_in[1] = 1'b1; waitc(8);
    rd(STAT, r); check("R11 held level passes", 32'(r[1]), 1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule